// File: doc/BRIEF.md
# Battery Temperature-Zone Charge Governor

This block watches four threshold comparators on a battery thermistor divider and sorts the battery temperature into one of five zones: cold, cool, normal, warm and hot. From the settled zone and a few static configuration fields it derives three things. The first is the percentage of the normal charge current to apply. The second is a signed millivolt offset for the downstream charge-voltage setpoint. The third is a request to suspend charging. It also decides whether charge termination may fire. It runs the charge safety timer, which stops while charging is suspended and counts at half rate while the current is reduced.

Zone changes are reported to a host controller. A status vector shows the current zone. Sticky per-zone flags latch each entry and are cleared by a read-clear strobe. An active-low interrupt pulse is raised unless the zone's mask bit is set. An ignore control forces the temperature to be treated as good and blanks all status.

Top module: `thermal_charge_governor`

## Requirements
- R1: Zone decode gives cold priority over hot, hot over cool, and cool over warm; no comparator asserted means normal. The status vector is one-hot or zero, with bit 3 = cold, bit 2 = cool, bit 1 = warm and bit 0 = hot. The normal zone reads all zero.
- R2: Comparator inputs pass through a two-flop synchronizer. A new decoded zone is adopted only after it has been stable for cfg_db_len+1 consecutive clocks, so shorter excursions leave the zone unchanged.
- R3: In the cold or hot zone, chg_suspend is 1, ichg_pct is 0 and ts_otg_ok is 0; in every other zone ts_otg_ok is 1.
- R4: In the cool zone, cfg_cool_isel selects ichg_pct as follows: 00 = suspend (pct 0), 01 = 20, 10 = 40, 11 = 100. The normal and warm zones give 100.
- R5: In the warm zone, cfg_warm_vsel = 000 requests suspend, and a value v from 1 to 7 gives vofs_mv = -100*v. Every other zone gives vofs_mv = 0.
- R6: term_req is 1 exactly when cfg_term_en, ibat_below_term, vbat_above_rechg and in_cv_loop are all 1 and charging is not suspended, in any zone. This includes a cool zone whose current is reduced.
- R7: While chg_en is 0, the safety timer count and its half-rate phase are cleared. While chg_en is 1, each tick advances the count by one; with a 20% or 40% cool current it advances only on every second tick; while suspended it does not move.
- R8: tmr_expired is 1 whenever tmr_count has reached cfg_tmr_limit, and the count then stops advancing.
- R9: With cfg_ignore set, status reads zero, chg_suspend is 0, ichg_pct is 100, vofs_mv is 0, ts_otg_ok is 1, and no flag or interrupt is produced.
- R10: Entering cold, cool, warm or hot sets the matching flag bit (same bit order as status), whatever the mask. Flags stay set until flag_clr is pulsed. A set that coincides with a clear wins.
- R11: Each zone entry that sets a flag whose cfg_mask bit is 0 drives int_n low for exactly INT_LEN clocks. Entering normal, or entering a masked zone, leaves int_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_cold | input | 1 | Temperature below the coldest threshold |
| cmp_cool | input | 1 | Temperature below the cool threshold |
| cmp_warm | input | 1 | Temperature above the warm threshold |
| cmp_hot | input | 1 | Temperature above the hottest threshold |
| cfg_ignore | input | 1 | Ignore thermistor, treat temperature as good |
| cfg_term_en | input | 1 | Termination enable |
| cfg_cool_isel | input | 2 | Cool-zone current select |
| cfg_warm_vsel | input | 3 | Warm-zone voltage offset select |
| cfg_db_len | input | DB_W | Debounce length in clocks minus one |
| cfg_tmr_limit | input | TMR_W | Safety timer expiry count |
| cfg_mask | input | 4 | Interrupt masks {cold,cool,warm,hot} |
| chg_en | input | 1 | Charge cycle requested; 0 clears the timer |
| tick | input | 1 | Safety timer prescaler tick |
| ibat_below_term | input | 1 | Charge current below termination threshold |
| vbat_above_rechg | input | 1 | Battery voltage above recharge level |
| in_cv_loop | input | 1 | Charger is in constant-voltage regulation |
| flag_clr | input | 1 | Read-clear strobe for flags |
| zone_stat | output | 4 | Zone status {cold,cool,warm,hot} |
| zone_flags | output | 4 | Sticky zone flags, same order |
| int_n | output | 1 | Active-low interrupt pulse |
| chg_suspend | output | 1 | Charge suspend request |
| ichg_pct | output | 7 | Charge current as percent of normal |
| vofs_mv | output | VOFS_W | Signed charge-voltage offset in mV |
| term_req | output | 1 | Termination condition met |
| ts_otg_ok | output | 1 | Temperature acceptable for output mode |
| tmr_count | output | TMR_W | Safety timer count |
| tmr_expired | output | 1 | Safety timer reached limit |

## Verification
The bench builds the block with DB_W=4, TMR_W=6 and INT_LEN=3. With these values every debounce window and timer limit can be reached in a few dozen clocks. The bench sweeps all sixteen comparator combinations, every cool current code and every warm voltage code. The small timer width makes both expiry and the half-rate behaviour observable with short tick bursts. The short interrupt length lets the bench count each pulse cycle by cycle.

// File: rtl/thermal_charge_governor.sv
module thermal_charge_governor #(
  parameter int DB_W    = 8,
  parameter int TMR_W   = 16,
  parameter int INT_LEN = 4,
  parameter int VOFS_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_cold,
  input  logic                     cmp_cool,
  input  logic                     cmp_warm,
  input  logic                     cmp_hot,
  input  logic                     cfg_ignore,
  input  logic                     cfg_term_en,
  input  logic [1:0]               cfg_cool_isel,
  input  logic [2:0]               cfg_warm_vsel,
  input  logic [DB_W-1:0]          cfg_db_len,
  input  logic [TMR_W-1:0]         cfg_tmr_limit,
  input  logic [3:0]               cfg_mask,
  input  logic                     chg_en,
  input  logic                     tick,
  input  logic                     ibat_below_term,
  input  logic                     vbat_above_rechg,
  input  logic                     in_cv_loop,
  input  logic                     flag_clr,
  output logic [3:0]               zone_stat,
  output logic [3:0]               zone_flags,
  output logic                     int_n,
  output logic                     chg_suspend,
  output logic [6:0]               ichg_pct,
  output logic signed [VOFS_W-1:0] vofs_mv,
  output logic                     term_req,
  output logic                     ts_otg_ok,
  output logic [TMR_W-1:0]         tmr_count,
  output logic                     tmr_expired
);

  localparam logic [2:0] Z_COLD = 3'd0;
  localparam logic [2:0] Z_COOL = 3'd1;
  localparam logic [2:0] Z_NORM = 3'd2;
  localparam logic [2:0] Z_WARM = 3'd3;
  localparam logic [2:0] Z_HOT  = 3'd4;
  localparam int IC_W = $clog2(INT_LEN + 1);

  logic [3:0]      s1, s2;
  logic [2:0]      raw, cand, zone;
  logic [DB_W-1:0] db_cnt;
  logic            upd;
  logic [3:0]      new_bit;
  logic            evt, evt_int;
  logic [IC_W-1:0] icnt;
  logic            ph;
  logic            cold_e, cool_e, warm_e, hot_e, reduced;
  logic [VOFS_W-1:0] mag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {cmp_cold, cmp_cool, cmp_warm, cmp_hot};
      s2 <= s1;
    end

  always_comb begin
    if (s2[3])      raw = Z_COLD;
    else if (s2[0]) raw = Z_HOT;
    else if (s2[2]) raw = Z_COOL;
    else if (s2[1]) raw = Z_WARM;
    else            raw = Z_NORM;
  end

  assign upd = (cand == raw) && (cand != zone) && (db_cnt >= cfg_db_len);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cand   <= Z_NORM;
      zone   <= Z_NORM;
      db_cnt <= '0;
    end else if (raw != cand) begin
      cand   <= raw;
      db_cnt <= '0;
    end else if (cand != zone) begin
      if (upd) begin
        zone   <= cand;
        db_cnt <= '0;
      end else begin
        db_cnt <= db_cnt + 1'b1;
      end
    end

  always_comb begin
    case (cand)
      Z_COLD:  new_bit = 4'b1000;
      Z_COOL:  new_bit = 4'b0100;
      Z_WARM:  new_bit = 4'b0010;
      Z_HOT:   new_bit = 4'b0001;
      default: new_bit = 4'b0000;
    endcase
  end

  assign evt     = upd && !cfg_ignore && (new_bit != 4'b0000);
  assign evt_int = evt && ((new_bit & cfg_mask) == 4'b0000);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) zone_flags <= '0;
    else if (evt) zone_flags <= (flag_clr ? 4'b0000 : zone_flags) | new_bit;
    else if (flag_clr) zone_flags <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) icnt <= '0;
    else if (evt_int) icnt <= IC_W'(INT_LEN);
    else if (icnt != '0) icnt <= icnt - 1'b1;

  assign int_n = (icnt == '0);

  assign cold_e = !cfg_ignore && (zone == Z_COLD);
  assign cool_e = !cfg_ignore && (zone == Z_COOL);
  assign warm_e = !cfg_ignore && (zone == Z_WARM);
  assign hot_e  = !cfg_ignore && (zone == Z_HOT);

  assign zone_stat   = {cold_e, cool_e, warm_e, hot_e};
  assign ts_otg_ok   = !(cold_e || hot_e);
  assign chg_suspend = cold_e || hot_e || (cool_e && cfg_cool_isel == 2'b00) ||
                       (warm_e && cfg_warm_vsel == 3'b000);
  assign reduced     = cool_e && (cfg_cool_isel == 2'b01 || cfg_cool_isel == 2'b10);

  always_comb begin
    if (chg_suspend)                          ichg_pct = 7'd0;
    else if (cool_e && cfg_cool_isel == 2'b01) ichg_pct = 7'd20;
    else if (cool_e && cfg_cool_isel == 2'b10) ichg_pct = 7'd40;
    else                                       ichg_pct = 7'd100;
  end

  assign mag     = VOFS_W'(cfg_warm_vsel) * VOFS_W'(100);
  assign vofs_mv = (warm_e && cfg_warm_vsel != 3'b000) ? -$signed(mag) : '0;

  assign term_req = cfg_term_en && ibat_below_term && vbat_above_rechg &&
                    in_cv_loop && !chg_suspend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_count <= '0;
      ph        <= 1'b0;
    end else if (!chg_en) begin
      tmr_count <= '0;
      ph        <= 1'b0;
    end else if (tick && !chg_suspend && tmr_count < cfg_tmr_limit) begin
      if (reduced) begin
        ph <= ~ph;
        if (ph) tmr_count <= tmr_count + 1'b1;
      end else begin
        tmr_count <= tmr_count + 1'b1;
      end
    end

  assign tmr_expired = (tmr_count >= cfg_tmr_limit);

endmodule

module thermal_charge_governor_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_ignore,
  input logic             cfg_term_en,
  input logic             chg_en,
  input logic             flag_clr,
  input logic [3:0]       zone_stat,
  input logic [3:0]       zone_flags,
  input logic             chg_suspend,
  input logic             term_req,
  input logic             ts_otg_ok,
  input logic [TMR_W-1:0] tmr_count,
  input logic [TMR_W-1:0] cfg_tmr_limit
);

  p_stat_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(zone_stat));

  p_extreme_otg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_stat[3] || zone_stat[0]) |-> (chg_suspend && !ts_otg_ok));

  p_term_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> (cfg_term_en && !chg_suspend));

  p_timer_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && chg_suspend) |=> (tmr_count == $past(tmr_count)));

  p_timer_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |=> (TMR_W'(tmr_count - $past(tmr_count)) <= TMR_W'(1)));

  p_timer_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && tmr_count >= cfg_tmr_limit) |=> $stable(tmr_count));

  p_ignore_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ignore |-> (zone_stat == 4'b0000 && !chg_suspend && ts_otg_ok));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((zone_flags & $past(zone_flags)) == $past(zone_flags)));

endmodule

bind thermal_charge_governor thermal_charge_governor_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ignore(cfg_ignore), .cfg_term_en(cfg_term_en),
  .chg_en(chg_en), .flag_clr(flag_clr), .zone_stat(zone_stat),
  .zone_flags(zone_flags), .chg_suspend(chg_suspend), .term_req(term_req),
  .ts_otg_ok(ts_otg_ok), .tmr_count(tmr_count), .cfg_tmr_limit(cfg_tmr_limit)
);

// File: tb/sim_thermal_charge_governor.sv
module sim_thermal_charge_governor;
  localparam int DB_W = 4, TMR_W = 6, INT_LEN = 3, VOFS_W = 12;

  logic clk = 0, rst_n = 0;
  logic cmp_cold = 0, cmp_cool = 0, cmp_warm = 0, cmp_hot = 0;
  logic cfg_ignore = 0, cfg_term_en = 1;
  logic [1:0] cfg_cool_isel = 2'b11;
  logic [2:0] cfg_warm_vsel = 3'b001;
  logic [DB_W-1:0] cfg_db_len = 4'd4;
  logic [TMR_W-1:0] cfg_tmr_limit = 6'd63;
  logic [3:0] cfg_mask = 4'b0000;
  logic chg_en = 0, tick = 0, ibat_below_term = 0, vbat_above_rechg = 0;
  logic in_cv_loop = 0, flag_clr = 0;
  logic [3:0] zone_stat, zone_flags;
  logic int_n, chg_suspend, term_req, ts_otg_ok, tmr_expired;
  logic [6:0] ichg_pct;
  logic signed [VOFS_W-1:0] vofs_mv;
  logic [TMR_W-1:0] tmr_count;

  int total = 0, bad = 0, int_low = 0;

  always #2.5 clk = ~clk;

  thermal_charge_governor #(.DB_W(DB_W), .TMR_W(TMR_W), .INT_LEN(INT_LEN), .VOFS_W(VOFS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_cold(cmp_cold), .cmp_cool(cmp_cool),
    .cmp_warm(cmp_warm), .cmp_hot(cmp_hot), .cfg_ignore(cfg_ignore),
    .cfg_term_en(cfg_term_en), .cfg_cool_isel(cfg_cool_isel),
    .cfg_warm_vsel(cfg_warm_vsel), .cfg_db_len(cfg_db_len),
    .cfg_tmr_limit(cfg_tmr_limit), .cfg_mask(cfg_mask), .chg_en(chg_en),
    .tick(tick), .ibat_below_term(ibat_below_term),
    .vbat_above_rechg(vbat_above_rechg), .in_cv_loop(in_cv_loop),
    .flag_clr(flag_clr), .zone_stat(zone_stat), .zone_flags(zone_flags),
    .int_n(int_n), .chg_suspend(chg_suspend), .ichg_pct(ichg_pct),
    .vofs_mv(vofs_mv), .term_req(term_req), .ts_otg_ok(ts_otg_ok),
    .tmr_count(tmr_count), .tmr_expired(tmr_expired));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!int_n) int_low++;
    end
  endtask

  task automatic set_cmp(input logic [3:0] v);
    {cmp_hot, cmp_warm, cmp_cool, cmp_cold} = v;
    cyc(20);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(1); tick = 0; cyc(1);
    end
  endtask

  task automatic tmr_clear;
    chg_en = 0; cyc(1); chg_en = 1;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [3:0] N = 4'b0000, CO = 4'b0001, CL = 4'b0010, WM = 4'b0100, HT = 4'b1000;

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 reset stat", zone_stat, 0);
    chk("R10 reset flags", zone_flags, 0);
    chk("R11 reset int_n", int_n, 1);
    chk("R7 reset timer", tmr_count, 0);

    // R1 / R3 sweep of all comparator combinations
    for (int c = 0; c < 16; c++) begin
      int e;
      set_cmp(4'(c));
      e = c[0] ? 8 : c[3] ? 1 : c[1] ? 4 : c[2] ? 2 : 0;
      chk($sformatf("R1 stat cmp=%0d", c), zone_stat, e);
      chk($sformatf("R3 suspend cmp=%0d", c), chg_suspend, (e == 8 || e == 1) ? 1 : 0);
      chk($sformatf("R3 otg cmp=%0d", c), ts_otg_ok, (e == 8 || e == 1) ? 0 : 1);
      if (e == 8 || e == 1) chk("R3 pct", ichg_pct, 0);
    end

    // R4 cool current select
    set_cmp(CL);
    for (int s = 0; s < 4; s++) begin
      cfg_cool_isel = 2'(s); cyc(1);
      chk($sformatf("R4 pct isel=%0d", s), ichg_pct, s == 0 ? 0 : s == 1 ? 20 : s == 2 ? 40 : 100);
      chk($sformatf("R4 suspend isel=%0d", s), chg_suspend, s == 0 ? 1 : 0);
      chk("R5 cool vofs", vofs_mv, 0);
    end
    cfg_cool_isel = 2'b11;

    // R5 warm voltage select
    set_cmp(WM);
    for (int v = 0; v < 8; v++) begin
      cfg_warm_vsel = 3'(v); cyc(1);
      chk($sformatf("R5 vofs vsel=%0d", v), int'(vofs_mv), -100 * v);
      chk($sformatf("R5 suspend vsel=%0d", v), chg_suspend, v == 0 ? 1 : 0);
      if (v != 0) chk("R4 warm pct", ichg_pct, 100);
    end
    cfg_warm_vsel = 3'b001;
    set_cmp(N);
    chk("R4 normal pct", ichg_pct, 100);
    chk("R5 normal vofs", vofs_mv, 0);

    // R6 termination
    for (int k = 0; k < 16; k++) begin
      {cfg_term_en, ibat_below_term, vbat_above_rechg, in_cv_loop} = 4'(k);
      cyc(1);
      chk($sformatf("R6 term k=%0d", k), term_req, k == 15 ? 1 : 0);
    end
    set_cmp(CL); cfg_cool_isel = 2'b01; cyc(1);
    chk("R6 term reduced cool", term_req, 1);
    cfg_cool_isel = 2'b00; cyc(1);
    chk("R6 term suspended", term_req, 0);
    cfg_cool_isel = 2'b11;
    {cfg_term_en, ibat_below_term, vbat_above_rechg, in_cv_loop} = 4'b1000;

    // R7 / R8 timer
    set_cmp(N); tmr_clear; ticks(6);
    chk("R7 full rate", tmr_count, 6);
    chg_en = 0; cyc(1);
    chk("R7 clear on chg_en low", tmr_count, 0);
    set_cmp(CL);
    for (int s = 1; s < 4; s++) begin
      cfg_cool_isel = 2'(s); tmr_clear; ticks(7);
      chk($sformatf("R7 cool isel=%0d", s), tmr_count, s == 3 ? 7 : 3);
    end
    cfg_cool_isel = 2'b00; tmr_clear; ticks(5);
    chk("R7 frozen cool suspend", tmr_count, 0);
    cfg_cool_isel = 2'b11;
    set_cmp(WM); tmr_clear; ticks(4);
    chk("R7 warm full", tmr_count, 4);
    set_cmp(HT); ticks(4);
    chk("R7 frozen hot", tmr_count, 4);
    set_cmp(N); cfg_tmr_limit = 6'd5; tmr_clear; ticks(4);
    chk("R8 not expired", tmr_expired, 0);
    ticks(5);
    chk("R8 saturate", tmr_count, 5);
    chk("R8 expired", tmr_expired, 1);
    chg_en = 0; cfg_tmr_limit = 6'd63; cyc(1);

    // R9 ignore
    cfg_ignore = 1;
    flag_clr = 1; cyc(1); flag_clr = 0;
    int_low = 0;
    set_cmp(CO);
    chk("R9 stat", zone_stat, 0);
    chk("R9 suspend", chg_suspend, 0);
    chk("R9 otg", ts_otg_ok, 1);
    chk("R9 pct", ichg_pct, 100);
    chk("R9 flags", zone_flags, 0);
    chk("R9 int", int_low, 0);
    set_cmp(N);
    cfg_ignore = 0;

    // R11 / R10 interrupt and flags
    int_low = 0;
    set_cmp(WM);
    chk("R11 int width", int_low, INT_LEN);
    chk("R10 flag warm", zone_flags, 4'b0010);
    int_low = 0;
    set_cmp(N);
    chk("R11 no int on normal", int_low, 0);
    chk("R10 sticky", zone_flags, 4'b0010);
    flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);
    chk("R10 clear", zone_flags, 0);
    cfg_mask = 4'b0010; int_low = 0;
    set_cmp(WM);
    chk("R11 masked", int_low, 0);
    chk("R10 flag despite mask", zone_flags, 4'b0010);
    set_cmp(HT);
    chk("R11 hot int", int_low, INT_LEN);
    chk("R10 flags accumulate", zone_flags, 4'b0011);
    cfg_mask = 4'b0000;
    set_cmp(N);

    // R2 debounce
    int_low = 0;
    cmp_hot = 1; cyc(3); cmp_hot = 0; cyc(20);
    chk("R2 glitch stat", zone_stat, 0);
    chk("R2 glitch int", int_low, 0);
    cmp_hot = 1; cyc(6);
    chk("R2 not yet", zone_stat, 0);
    cyc(2);
    chk("R2 adopted", zone_stat, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule